// File: doc/BRIEF.md
# Operating Mode Transition Controller

This block holds the chip's present operating mode and moves it on software request. Software writes a 4-bit target code to a control register on a simple register bus. The block checks that code against the transitions allowed from the present mode. It either takes the new mode on the next clock or rejects the request and sets a sticky error flag. Two low-power modes, a halt and a stop, are left through hardware events rather than writes. The block then returns to the run mode that was active before entry.

Two small configuration fields drive two registered control outputs. One releases the chip's pads to high impedance while in the safe mode. The other stops the system clock while in the test mode. A stopped test mode accepts no further request, so only a reset leaves it. Consumers watch `cur_mode`, `pad_hiz` and `sysclk_stop`, and software reads the same state back over the bus.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge and after it, `cur_mode` is 4'b0011, and `illegal_flag`, `pad_hiz`, `sysclk_stop` and `bus_rdata` are all zero.
- R2: Mode codes are: test 4'b0001, safe 4'b0010, default-run 4'b0011, run0 to run3 4'b0100 to 4'b0111, halt 4'b1000, stop 4'b1010. A write to address 0 takes bits [3:0] as the target. A read of address 0 returns the present mode in bits [3:0], address 1 the flag in bit 0, address 2 the pad-release bit in bit 0, and address 3 the clock field in bits [3:0]. `bus_rdata` shows the value one cycle after `bus_rd`.
- R3: The test code is accepted only when the present mode is default-run.
- R4: Codes run0 to run3 are accepted from default-run, from safe and from any run mode.
- R5: The halt and stop codes are accepted only from a run mode. The block records that run mode on entry.
- R6: The safe code is accepted from default-run, test or a run mode. The default-run code is accepted from safe, test or a run mode. Every other pairing and every unused code is rejected.
- R7: A halt or stop request that would be accepted, made while `irq_pend` is high, is aborted. The mode is unchanged and the flag is not set.
- R8: In halt, `irq_pend` returns the block to the recorded run mode, and `wake_evt` alone does nothing. In stop, either input returns it. Every target write made in halt or stop is rejected.
- R9: In test mode with the clock field (address 3, bits [3:0]) at 4'b1111, `sysclk_stop` goes high. Every request is then rejected until reset.
- R10: `pad_hiz` is high exactly when the mode is safe and the pad-release bit (address 2, bit 0) is set.
- R11: A rejected request sets `illegal_flag`. The flag stays set until a write to address 1 with bit 0 at 1 clears it. A write there with bit 0 at 0 leaves it unchanged.
- R12: An accepted request or a wake changes `cur_mode` on the clock edge that samples it. `pad_hiz` and `sysclk_stop` follow `cur_mode` and the configuration one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pend | input | 1 | Interrupt request pending |
| wake_evt | input | 1 | Wakeup event |
| cur_mode | output | 4 | Present mode code |
| illegal_flag | output | 1 | Sticky rejected-request flag |
| pad_hiz | output | 1 | Pad high-impedance enable |
| sysclk_stop | output | 1 | System clock stop |

## Verification
Two functions can fall in one cycle: a halt or stop entry request, and a pending interrupt that both aborts that entry and would otherwise wake the block. A low-power request can also coincide with a wake input while the block already sits in halt or stop. The random stimulus raises `irq_pend` and `wake_evt` independently of the target writes, and directed steps pair a halt write with `irq_pend` high. The bench model judges each such cycle by its rules: the abort leaves the mode and the flag unchanged, and a wake takes precedence over a rejected write in a low-power mode.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_TEST = 4'b0001;
  localparam logic [MODE_W-1:0] MD_SAFE = 4'b0010;
  localparam logic [MODE_W-1:0] MD_DRUN = 4'b0011;
  localparam logic [MODE_W-1:0] MD_RUN0 = 4'b0100;
  localparam logic [MODE_W-1:0] MD_HALT = 4'b1000;
  localparam logic [MODE_W-1:0] MD_STOP = 4'b1010;

  localparam logic [MODE_W-1:0] CLK_OFF_CODE = 4'b1111;

  localparam int REG_CTL   = 0;
  localparam int REG_FLAG  = 1;
  localparam int REG_SAFE  = 2;
  localparam int REG_TEST  = 3;

  function automatic logic is_run(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_lowpow(input logic [MODE_W-1:0] m);
    return (m == MD_HALT) || (m == MD_STOP);
  endfunction

  // Legal-transition table, indexed by target then by present mode.
  function automatic logic target_ok(input logic [MODE_W-1:0] cur,
                                     input logic [MODE_W-1:0] tgt);
    logic ok;
    case (tgt)
      MD_TEST:                    ok = (cur == MD_DRUN);
      MD_SAFE:                    ok = (cur == MD_DRUN) || (cur == MD_TEST) || is_run(cur);
      MD_DRUN:                    ok = (cur == MD_SAFE) || (cur == MD_TEST) || is_run(cur);
      4'b0100, 4'b0101,
      4'b0110, 4'b0111:           ok = (cur == MD_DRUN) || (cur == MD_SAFE) || is_run(cur);
      MD_HALT, MD_STOP:           ok = is_run(cur);
      default:                    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/opmode_regs.sv
module opmode_regs
  import opmode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              reject,
  output logic              req_valid,
  output logic [MODE_W-1:0] req_tgt,
  output logic              safe_float,
  output logic [MODE_W-1:0] test_clk,
  output logic              illegal_flag
);

  logic sel_ctl, sel_flag, sel_safe, sel_test;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign sel_ctl  = (bus_addr == ADDR_W'(REG_CTL));
  assign sel_flag = (bus_addr == ADDR_W'(REG_FLAG));
  assign sel_safe = (bus_addr == ADDR_W'(REG_SAFE));
  assign sel_test = (bus_addr == ADDR_W'(REG_TEST));

  assign req_valid = bus_wr && sel_ctl;
  assign req_tgt   = bus_wdata[MODE_W-1:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:MODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      safe_float <= 1'b0;
      test_clk   <= '0;
    end else if (bus_wr) begin
      if (sel_safe) safe_float <= bus_wdata[0];
      if (sel_test) test_clk   <= bus_wdata[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      illegal_flag <= 1'b0;
    else if (reject)
      illegal_flag <= 1'b1;
    else if (bus_wr && sel_flag && bus_wdata[0])
      illegal_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctl)  rd_mux[MODE_W-1:0] = cur_mode;
    if (sel_flag) rd_mux[0]          = illegal_flag;
    if (sel_safe) rd_mux[0]          = safe_float;
    if (sel_test) rd_mux[MODE_W-1:0] = test_clk;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_tgt,
  input  logic              irq_pend,
  input  logic              wake_evt,
  input  logic              clk_off,
  output logic [MODE_W-1:0] cur_mode,
  output logic              reject
);

  logic [MODE_W-1:0] saved_run;
  logic [MODE_W-1:0] mode_nxt;
  logic frozen, legal, accept, lp_req, lp_abort, lp_enter, wake_now;

  assign frozen   = (cur_mode == MD_TEST) && clk_off;
  assign legal    = target_ok(cur_mode, req_tgt) && !frozen;
  assign accept   = req_valid && legal;
  assign reject   = req_valid && !legal;
  assign lp_req   = accept && is_lowpow(req_tgt);
  assign lp_abort = lp_req && irq_pend;
  assign lp_enter = lp_req && !irq_pend;
  assign wake_now = ((cur_mode == MD_HALT) && irq_pend) ||
                    ((cur_mode == MD_STOP) && (irq_pend || wake_evt));

  always_comb begin
    mode_nxt = cur_mode;
    if (wake_now)
      mode_nxt = saved_run;
    else if (accept && !lp_abort)
      mode_nxt = req_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode  <= MD_DRUN;
      saved_run <= MD_RUN0;
    end else begin
      cur_mode <= mode_nxt;
      if (lp_enter) saved_run <= cur_mode;
    end
  end

endmodule

// File: rtl/opmode_outs.sv
module opmode_outs
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              safe_float,
  input  logic              clk_off,
  output logic              pad_hiz,
  output logic              sysclk_stop
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_hiz     <= 1'b0;
      sysclk_stop <= 1'b0;
    end else begin
      pad_hiz     <= (cur_mode == MD_SAFE) && safe_float;
      sysclk_stop <= (cur_mode == MD_TEST) && clk_off;
    end
  end

endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_pend,
  input  logic              wake_evt,
  output logic [3:0]        cur_mode,
  output logic              illegal_flag,
  output logic              pad_hiz,
  output logic              sysclk_stop
);

  logic              req_valid;
  logic [MODE_W-1:0] req_tgt;
  logic              reject;
  logic              safe_float;
  logic [MODE_W-1:0] test_clk;
  logic              clk_off;

  assign clk_off = (test_clk == CLK_OFF_CODE);

  opmode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .cur_mode     (cur_mode),
    .reject       (reject),
    .req_valid    (req_valid),
    .req_tgt      (req_tgt),
    .safe_float   (safe_float),
    .test_clk     (test_clk),
    .illegal_flag (illegal_flag)
  );

  opmode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_tgt   (req_tgt),
    .irq_pend  (irq_pend),
    .wake_evt  (wake_evt),
    .clk_off   (clk_off),
    .cur_mode  (cur_mode),
    .reject    (reject)
  );

  opmode_outs u_outs (
    .clk         (clk),
    .rst         (rst),
    .cur_mode    (cur_mode),
    .safe_float  (safe_float),
    .clk_off     (clk_off),
    .pad_hiz     (pad_hiz),
    .sysclk_stop (sysclk_stop)
  );

endmodule

// File: rtl/opmode_chk.sv
module opmode_chk
  import opmode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_pend,
  input logic [3:0]        cur_mode,
  input logic              illegal_flag,
  input logic              pad_hiz,
  input logic              sysclk_stop
);

  logic [3:0] prev_mode;
  logic       prev_ok;

  always_ff @(posedge clk) begin
    prev_mode <= cur_mode;
    prev_ok   <= !rst;
  end

  // R3: test mode is entered only from default-run
  p_test_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && cur_mode == MD_TEST && prev_mode != MD_TEST) |-> (prev_mode == MD_DRUN));

  // R5: low-power modes are entered only from a run mode
  p_lowpow_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && is_lowpow(cur_mode) && prev_mode != cur_mode) |-> is_run(prev_mode));

  // R7: low-power request with interrupt pending leaves mode and flag alone
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(REG_CTL) && is_lowpow(bus_wdata[3:0]) &&
     irq_pend && is_run(cur_mode))
    |=> ($stable(cur_mode) && !$rose(illegal_flag)));

  // R8: an interrupt in halt returns to a run mode
  p_halt_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MD_HALT && irq_pend) |=> is_run(cur_mode));

  // R10: pad release only follows the safe mode
  p_pad_safe_r10: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && pad_hiz) |-> (prev_mode == MD_SAFE));

  // R9: clock stop only follows the test mode
  p_clkstop_test_r9: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && sysclk_stop) |-> (prev_mode == MD_TEST));

  // R11: flag clears only after a write-one to its register
  p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && $fell(illegal_flag)) |->
      $past(bus_wr && bus_addr == ADDR_W'(REG_FLAG) && bus_wdata[0]));

endmodule

bind opmode_ctrl opmode_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .irq_pend     (irq_pend),
  .cur_mode     (cur_mode),
  .illegal_flag (illegal_flag),
  .pad_hiz      (pad_hiz),
  .sysclk_stop  (sysclk_stop)
);

// File: tb/opmode_ctrl_test.sv
module opmode_ctrl_test;

  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          irq_pend = 1'b0;
  logic          wake_evt = 1'b0;
  logic [3:0]    cur_mode;
  logic          illegal_flag;
  logic          pad_hiz;
  logic          sysclk_stop;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [3:0]    e_mode = 4'h3;
  logic [3:0]    e_saved = 4'h4;
  logic          e_flag = 1'b0;
  logic          e_float = 1'b0;
  logic [3:0]    e_ck = 4'h0;
  logic          e_pad = 1'b0;
  logic          e_clk = 1'b0;
  logic [DW-1:0] e_rd = '0;
  bit            rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  opmode_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_pend(irq_pend), .wake_evt(wake_evt), .cur_mode(cur_mode),
    .illegal_flag(illegal_flag), .pad_hiz(pad_hiz), .sysclk_stop(sysclk_stop)
  );

  // Allowed targets listed per present mode (R3..R6, R8, R9)
  function automatic bit may_go(input logic [3:0] c, input logic [3:0] t, input bit stopped);
    bit run_t;
    run_t = (t >= 4'h4) && (t <= 4'h7);
    if (stopped && c == 4'h1) return 1'b0;
    case (c)
      4'h3:                      return (t == 4'h1) || (t == 4'h2) || run_t;
      4'h2:                      return (t == 4'h3) || run_t;
      4'h1:                      return (t == 4'h2) || (t == 4'h3);
      4'h4, 4'h5, 4'h6, 4'h7:    return (t == 4'h2) || (t == 4'h3) || run_t ||
                                        (t == 4'h8) || (t == 4'hA);
      default:                   return 1'b0;
    endcase
  endfunction

  task automatic model_edge();
    logic [3:0] m0, t;
    bit rej;
    m0 = e_mode;
    rd_seen = bus_rd;
    if (rst) begin
      e_mode = 4'h3; e_saved = 4'h4; e_flag = 1'b0; e_float = 1'b0;
      e_ck = 4'h0; e_pad = 1'b0; e_clk = 1'b0; e_rd = '0;
      return;
    end
    if (bus_rd) begin
      case (bus_addr)
        4'd0:    e_rd = DW'(m0);
        4'd1:    e_rd = DW'(e_flag);
        4'd2:    e_rd = DW'(e_float);
        4'd3:    e_rd = DW'(e_ck);
        default: e_rd = '0;
      endcase
    end
    e_pad = (m0 == 4'h2) && e_float;
    e_clk = (m0 == 4'h1) && (e_ck == 4'hF);
    rej = 1'b0;
    if (bus_wr && bus_addr == 4'd0) begin
      t = bus_wdata[3:0];
      if (!may_go(m0, t, e_ck == 4'hF)) rej = 1'b1;
      else if ((t == 4'h8 || t == 4'hA) && irq_pend) ;
      else begin
        if (t == 4'h8 || t == 4'hA) e_saved = m0;
        e_mode = t;
      end
    end
    if ((m0 == 4'h8 && irq_pend) || (m0 == 4'hA && (irq_pend || wake_evt)))
      e_mode = e_saved;
    if (rej) e_flag = 1'b1;
    else if (bus_wr && bus_addr == 4'd1 && bus_wdata[0]) e_flag = 1'b0;
    if (bus_wr && bus_addr == 4'd2) e_float = bus_wdata[0];
    if (bus_wr && bus_addr == 4'd3) e_ck = bus_wdata[3:0];
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input string mtag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(mtag, DW'(cur_mode), DW'(e_mode));
    chk("R11 flag", DW'(illegal_flag), DW'(e_flag));
    chk("R10 pad", DW'(pad_hiz), DW'(e_pad));
    chk("R9 clkstop", DW'(sysclk_stop), DW'(e_clk));
    if (rd_seen) chk("R2 readback", bus_rdata, e_rd);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    rst = 1'b0;
  endtask

  task automatic put(input logic [3:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
  endtask

  task automatic get(input logic [3:0] a);
    bus_addr = a; bus_rd = 1'b1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    rst = 1'b1; get(4'd0);
    step("R1 reset mode");
    rst = 1'b1;
    step("R1 reset mode");
    // directed corners
    put(4'd2, 32'h1);          step("R10 cfg");
    put(4'd0, 32'h1);          step("R3 test from drun");
    put(4'd0, 32'h3);          step("R6 drun from test");
    put(4'd0, 32'h4);          step("R4 run0 from drun");
    put(4'd0, 32'h1);          step("R3 test from run rejected");
    put(4'd1, 32'h0);          step("R11 write zero");
    put(4'd1, 32'h1);          step("R11 clear");
    put(4'd0, 32'hC);          step("R6 unused code");
    put(4'd1, 32'h1);          step("R11 clear");
    irq_pend = 1'b1;
    put(4'd0, 32'h8);          step("R7 halt aborted");
    irq_pend = 1'b0;
    put(4'd0, 32'h8);          step("R12 halt entry");
    wake_evt = 1'b1;           step("R8 wake ignored in halt");
    put(4'd0, 32'h5);          step("R8 write in halt rejected");
    wake_evt = 1'b0; irq_pend = 1'b1;
                               step("R8 halt wake");
    irq_pend = 1'b0;
    put(4'd1, 32'h1);          step("R11 clear");
    put(4'd0, 32'h6);          step("R4 run2");
    put(4'd0, 32'hA);          step("R5 stop entry");
    wake_evt = 1'b1;           step("R8 stop wake");
    wake_evt = 1'b0;
    put(4'd0, 32'h2);          step("R6 safe from run");
                               step("R10 pad follows");
    put(4'd0, 32'h7);          step("R4 run3 from safe");
    put(4'd0, 32'h3);          step("R6 drun from run");
    put(4'd3, 32'hF);          step("R9 cfg");
    put(4'd0, 32'h1);          step("R3 test");
                               step("R9 stop asserted");
    put(4'd0, 32'h3);          step("R9 exit rejected");
    get(4'd3);                 step("R2 read clk field");
    get(4'd0);                 step("R2 read mode");
    rst = 1'b1;                step("R1 reset exits test");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      irq_pend = ($urandom % 5) == 0;
      wake_evt = ($urandom % 5) == 0;
      if (r < 8) begin
        logic [3:0] t;
        case ($urandom % 12)
          0: t = 4'h1; 1: t = 4'h2; 2: t = 4'h3; 3: t = 4'h4;
          4: t = 4'h5; 5: t = 4'h6; 6: t = 4'h7; 7: t = 4'h8;
          8: t = 4'hA; default: t = 4'($urandom);
        endcase
        put(4'd0, DW'(t));
      end else if (r < 10) put(4'd2, DW'($urandom % 2));
      else if (r < 11)   put(4'd3, (($urandom % 2) == 0) ? 32'hF : DW'($urandom % 16));
      else if (r < 13)   put(4'd1, DW'($urandom % 2));
      if (($urandom % 3) == 0) begin
        bus_rd = 1'b1;
        if (!bus_wr) bus_addr = 4'($urandom % 5);
      end
      if (($urandom % 400) == 0) rst = 1'b1;
      step("R6 random mode");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule